// File: doc/BRIEF.md
# Hotplug Event Status Registers

This block records slot insertion and removal events for a 32-slot bus and processor arrival and departure events for up to 256 processors. Each slot event leaves behind exactly one bit, in either an "arrived" bitmap or a "departed" bitmap. Firmware reads that bit to learn which slot changed and in which direction. Any slot event raises a bus-hotplug flag, and any processor event raises a processor-hotplug flag. Both flags sit in a small event status byte that software clears by writing ones. A separate interrupt combiner consumes the two flags.

Software reaches everything through one register port. Writes are single-cycle. Read data is combinational from the address. The port gives access to the two slot bitmaps, an eject command register, a fixed mask of slots that may be removed, the event status byte, and a 32-byte processor presence map. A nonzero write to the eject register names a slot by its lowest set bit. If that slot is removable, the block emits a one-cycle eject request that carries the slot number. Removing the device is left to logic outside this block.

Top module: `hotplug_evt_regs`

## Requirements
- R1: After reset the arrived and departed bitmaps are 0 and the event status byte is 0. In the processor map, bits 0 to BOOT_CPUS-1 are 1 and every other bit is 0.
- R2: A slot event with slot_insert=1 and slot_cold=0 updates both bitmaps. After it, arrived (offset 0x00) equals 1<<slot_num and departed (offset 0x04) equals 0.
- R3: A slot event with slot_insert=0 updates both bitmaps, whatever the value of slot_cold. After it, departed equals 1<<slot_num and arrived equals 0.
- R4: A slot event with slot_insert=1 and slot_cold=1 leaves both bitmaps and the event status byte unchanged.
- R5: In the event status byte (offset 0x10, bits [7:0]), bit 1 (bus_flag) is set by every slot event that R4 does not exclude. Bit 2 (cpu_flag) is set by every processor add or remove. The other bits always read 0.
- R6: Writing offset 0x10 clears each flag whose bit is 1 in wdata[7:0]. If an event sets a flag in the same cycle as a write clears it, the flag ends up set.
- R7: Offsets 0x00 and 0x04 are 32-bit read/write registers. If a slot event falls in the same cycle as a write to either of them, the event's result is what remains.
- R8: A write of a nonzero value to offset 0x08 selects slot k, the index of the lowest set bit of the value. If slot k is removable, eject_req is 1 for exactly the next cycle and eject_slot equals k. A write of zero, or a value whose selected slot is not removable, gives no pulse. Reads of offset 0x08 return 0.
- R9: Offset 0x0C reads the inverse of the NONHP_MASK parameter, with a 1 for each removable slot. Writes to offset 0x0C change nothing.
- R10: Processor n is bit n%8 of the byte read at offset 0x20+n/8, returned in rdata[7:0]. cpu_add sets the bit for cpu_idx and cpu_rem clears it. If both are asserted in the same cycle, the add wins.
- R11: Reads of any offset not listed above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| slot_evt | input | 1 | Slot event strobe |
| slot_num | input | 5 | Slot that changed |
| slot_insert | input | 1 | 1 for insertion, 0 for removal |
| slot_cold | input | 1 | Insertion was present at boot |
| cpu_add | input | 1 | Processor arrival strobe |
| cpu_rem | input | 1 | Processor departure strobe |
| cpu_idx | input | 8 | Processor index |
| eject_req | output | 1 | One-cycle eject request |
| eject_slot | output | 5 | Slot to eject |
| bus_flag | output | 1 | Slot hotplug event flag |
| cpu_flag | output | 1 | Processor hotplug event flag |

## Verification
A hardware event and a software write can target the same state in the same cycle. A slot event can coincide with a write to one of the slot bitmaps, and an event can set a status flag in the cycle that software writes one to clear it. The bench provokes both collisions by raising the event strobe and the write strobe on the same clock edge. It then reads the register back and expects the event's outcome: the one-hot bitmap value, and the flag still set. Simultaneous add and remove of the same processor is judged in the same way, and the add must win.

// File: rtl/hotplug_evt_regs.sv
module hotplug_evt_regs #(
  parameter int MAX_CPUS = 256,
  parameter int BOOT_CPUS = 10,
  parameter logic [31:0] NONHP_MASK = 32'h0000_0003
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        slot_evt,
  input  logic [4:0]  slot_num,
  input  logic        slot_insert,
  input  logic        slot_cold,
  input  logic        cpu_add,
  input  logic        cpu_rem,
  input  logic [7:0]  cpu_idx,
  output logic        eject_req,
  output logic [4:0]  eject_slot,
  output logic        bus_flag,
  output logic        cpu_flag
);
  localparam logic [5:0] A_UP = 6'h00, A_DN = 6'h04, A_EJ = 6'h08, A_RM = 6'h0C, A_ST = 6'h10;
  localparam logic [31:0] REMOVABLE = ~NONHP_MASK;

  function automatic logic [255:0] boot_map();
    logic [255:0] m;
    for (int i = 0; i < 256; i++) m[i] = (i < BOOT_CPUS) && (i < MAX_CPUS);
    return m;
  endfunction
  localparam logic [255:0] CPU_INIT = boot_map();

  function automatic logic [4:0] low_idx(input logic [31:0] v);
    logic [4:0] k;
    k = 5'd0;
    for (int i = 31; i >= 0; i--) if (v[i]) k = 5'(i);
    return k;
  endfunction

  logic [31:0]  up_map, dn_map;
  logic [255:0] cpu_map;
  logic         slot_hot, cpu_ok, cpu_evt, ej_fire;
  logic [4:0]   ej_k;

  assign slot_hot = slot_evt && !(slot_insert && slot_cold);
  assign cpu_ok   = 32'(cpu_idx) < MAX_CPUS;
  assign cpu_evt  = (cpu_add || cpu_rem) && cpu_ok;
  assign ej_k     = low_idx(reg_wdata);
  assign ej_fire  = reg_wr && reg_addr == A_EJ && reg_wdata != 32'd0 && REMOVABLE[ej_k];

  always_ff @(posedge clk) begin
    if (rst) begin
      up_map <= '0;
      dn_map <= '0;
    end else if (slot_hot) begin
      up_map <= slot_insert ? (32'd1 << slot_num) : 32'd0;
      dn_map <= slot_insert ? 32'd0 : (32'd1 << slot_num);
    end else if (reg_wr) begin
      if (reg_addr == A_UP) up_map <= reg_wdata;
      if (reg_addr == A_DN) dn_map <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_flag <= 1'b0;
      cpu_flag <= 1'b0;
    end else begin
      bus_flag <= slot_hot | (bus_flag & ~(reg_wr && reg_addr == A_ST && reg_wdata[1]));
      cpu_flag <= cpu_evt  | (cpu_flag & ~(reg_wr && reg_addr == A_ST && reg_wdata[2]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_map <= CPU_INIT;
    else if (cpu_ok) begin
      if (cpu_add) cpu_map[cpu_idx] <= 1'b1;
      else if (cpu_rem) cpu_map[cpu_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eject_req  <= 1'b0;
      eject_slot <= 5'd0;
    end else begin
      eject_req <= ej_fire;
      if (ej_fire) eject_slot <= ej_k;
    end
  end

  always_comb begin
    reg_rdata = 32'd0;
    if (reg_addr[5]) reg_rdata = {24'd0, cpu_map[{reg_addr[4:0], 3'b000} +: 8]};
    else case (reg_addr)
      A_UP: reg_rdata = up_map;
      A_DN: reg_rdata = dn_map;
      A_RM: reg_rdata = REMOVABLE;
      A_ST: reg_rdata = {29'd0, cpu_flag, bus_flag, 1'b0};
      default: reg_rdata = 32'd0;
    endcase
  end

  // R2
  ins_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    slot_evt && slot_insert && !slot_cold |=> $countones(up_map) == 1 && dn_map == 32'd0);
  // R3
  rem_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    slot_evt && !slot_insert |=> $countones(dn_map) == 1 && up_map == 32'd0);
  // R4
  cold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    slot_evt && slot_insert && slot_cold && !reg_wr |=> $stable(up_map) && $stable(dn_map));
  // R5
  bus_flag_chk: assert property (@(posedge clk) disable iff (rst)
    slot_evt && !(slot_insert && slot_cold) |=> bus_flag);
  // R5
  cpu_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_add || cpu_rem) |=> cpu_flag);
  // R8
  eject_src_chk: assert property (@(posedge clk) disable iff (rst)
    eject_req |-> $past(reg_wr) && $past(reg_addr) == A_EJ && REMOVABLE[eject_slot]);
  // R10
  add_wins_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_add && cpu_ok |=> cpu_map[$past(cpu_idx)]);
endmodule

// File: tb/sim_hotplug_evt_regs.sv
`timescale 1ns/1ps
module sim_hotplug_evt_regs;
  logic clk = 0, rst = 1;
  logic [5:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic slot_evt = 0, slot_insert = 0, slot_cold = 0, cpu_add = 0, cpu_rem = 0;
  logic [4:0] slot_num = 0, eject_slot;
  logic [7:0] cpu_idx = 0;
  logic eject_req, bus_flag, cpu_flag;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hotplug_evt_regs u0 (.*);

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic slot(input logic [4:0] n, input logic ins, input logic cold);
    @(negedge clk); slot_evt = 1; slot_num = n; slot_insert = ins; slot_cold = cold;
    @(negedge clk); slot_evt = 0;
  endtask

  task automatic cpu(input logic [7:0] n, input logic add, input logic rem);
    @(negedge clk); cpu_idx = n; cpu_add = add; cpu_rem = rem;
    @(negedge clk); cpu_add = 0; cpu_rem = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(6'h00, d); check("R1 up", d, 0);
    rd(6'h04, d); check("R1 down", d, 0);
    rd(6'h10, d); check("R1 status", d, 0);
    rd(6'h20, d); check("R1 cpu byte0", d, 32'hff);
    rd(6'h21, d); check("R1 cpu byte1", d, 32'h03);
    rd(6'h22, d); check("R1 cpu byte2", d, 0);
  endtask

  task automatic t_slots();
    logic [31:0] d;
    slot(5'd7, 1, 0);
    rd(6'h00, d); check("R2 up", d, 32'h80);
    rd(6'h04, d); check("R2 down", d, 0);
    rd(6'h10, d); check("R5 bus flag", d, 32'h2);
    wr(6'h10, 32'h2);
    rd(6'h10, d); check("R6 w1c", d, 0);
    slot(5'd31, 0, 1);
    rd(6'h00, d); check("R3 up", d, 0);
    rd(6'h04, d); check("R3 down", d, 32'h8000_0000);
    wr(6'h10, 32'h2);
    slot(5'd3, 1, 1);
    rd(6'h04, d); check("R4 down kept", d, 32'h8000_0000);
    rd(6'h00, d); check("R4 up kept", d, 0);
    rd(6'h10, d); check("R4 no flag", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(6'h00, 32'hdead_beef);
    rd(6'h00, d); check("R7 up rw", d, 32'hdead_beef);
    wr(6'h04, 32'h1234_5678);
    rd(6'h04, d); check("R7 down rw", d, 32'h1234_5678);
    rd(6'h0C, d); check("R9 removable", d, 32'hffff_fffc);
    wr(6'h0C, 32'h0);
    rd(6'h0C, d); check("R9 write ignored", d, 32'hffff_fffc);
    rd(6'h14, d); check("R11 unmapped", d, 0);
    rd(6'h08, d); check("R8 eject reads 0", d, 0);
  endtask

  task automatic t_eject();
    @(negedge clk); reg_addr = 6'h08; reg_wdata = 32'h50; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
    check("R8 pulse", eject_req, 1); check("R8 slot", eject_slot, 4);
    @(negedge clk); check("R8 one cycle", eject_req, 0);
    wr(6'h08, 32'h0); check("R8 zero no pulse", eject_req, 0);
    wr(6'h08, 32'h6); check("R8 fixed slot no pulse", eject_req, 0);
    wr(6'h08, 32'h8000_0000);
    check("R8 pulse31", eject_req, 1); check("R8 slot31", eject_slot, 31);
  endtask

  task automatic t_cpu();
    logic [31:0] d;
    wr(6'h10, 32'h6);
    cpu(8'd3, 0, 1);
    rd(6'h20, d); check("R10 remove", d, 32'hf7);
    rd(6'h10, d); check("R5 cpu flag", d, 32'h4);
    cpu(8'd40, 1, 0);
    rd(6'h25, d); check("R10 add", d, 32'h01);
    cpu(8'd255, 1, 0);
    rd(6'h3F, d); check("R10 top cpu", d, 32'h80);
    cpu(8'd3, 1, 1);
    rd(6'h20, d); check("R10 add wins", d, 32'hff);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk);
    slot_evt = 1; slot_num = 5'd9; slot_insert = 1; slot_cold = 0;
    reg_addr = 6'h00; reg_wdata = 32'hffff_ffff; reg_wr = 1;
    @(negedge clk); slot_evt = 0; reg_wr = 0;
    rd(6'h00, d); check("R7 event beats write", d, 32'h200);
    @(negedge clk);
    slot_evt = 1; slot_num = 5'd2; slot_insert = 0;
    reg_addr = 6'h10; reg_wdata = 32'h6; reg_wr = 1;
    @(negedge clk); slot_evt = 0; reg_wr = 0;
    rd(6'h10, d); check("R6 set beats clear", d, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset(); t_slots(); t_regs(); t_eject(); t_cpu(); t_collide();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule